// File: doc/BRIEF.md
# Dual-Mode Multiplexed Bus Slave Interface

This block is the slave side of an 8-bit bus on which the address and the data share the same wires. A master first places a register address on the bus and marks it with an address strobe. It then moves one byte in either direction. A mode input picks one of two strobe conventions at run time, on the same pins. With the mode high, one pin is an active-high data strobe and a second pin is a read/write level. With the mode low, the same two pins act as an active-low read strobe and an active-low write strobe.

All bus inputs are brought into the system clock domain through a synchronizer bank of identical depth, so the pins stay aligned with one another. Every decision is made on the synchronized copies. The block keeps a 7-bit register address. It issues a one-cycle read strobe and a one-cycle write strobe to a register file, which sits outside the block. It drives the read data back with a separate output enable for the external tri-state buffer. The enable is low after reset. An active-low chip select gates every access, and a power-fail input overrides the chip select. A pull-down resistor on the mode pin is expected, so that a floating pin selects the split-strobe convention.

Top module: `mbus_slave`

## Requirements
- R1: `mode_i` = 1 selects the data-strobe convention (`ds_rd_i` is an active-high data strobe, `rw_wr_i` = 1 means read). `mode_i` = 0 selects the split convention (`ds_rd_i` is an active-low read strobe, `rw_wr_i` is an active-low write strobe).
- R2: A falling edge of the synchronized address strobe loads `ad_i[6:0]` into `reg_addr_o`. Bit 7 of the bus is dropped. The new address is visible three clock cycles after the pin edge.
- R3: A rising edge of the synchronized address strobe clears `reg_addr_o` to 0, whatever the state of the chip select.
- R4: In data-strobe mode, `ad_oe_o` is 1 while the data strobe is high, `rw_wr_i` is 1 and the chip is selected. `ad_oe_o` lags the pins by three clock cycles and falls the same way once the strobe goes low.
- R5: In data-strobe mode, a falling data strobe with `rw_wr_i` = 0 causes a write. The written byte is the bus value last sampled while the strobe was high.
- R6: In split mode, `ad_oe_o` is 1 while the read strobe is low and the chip is selected, with the same three-cycle lag. It returns to 0 once the read strobe goes high.
- R7: In split mode, a rising edge of the write strobe causes a write of the bus value last sampled while the write strobe was low.
- R8: Every write is a single-cycle `reg_wr_o` pulse, with `reg_addr_o` and `reg_wdata_o` valid in that cycle.
- R9: With `cs_n_i` = 1, no read drive and no write take place, but the address strobe still loads and clears the address.
- R10: With `pwr_fail_i` = 1, the chip select counts as inactive. No write happens and the bus is not driven.
- R11: `reg_rd_o` pulses for one cycle at the start of each read window. While `ad_oe_o` = 1, `ad_o` carries `reg_rdata_i` for the latched address.
- R12: During reset, `ad_oe_o`, `reg_wr_o`, `reg_rd_o` and `reg_addr_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | Strobe convention select (1 data strobe, 0 split strobes) |
| as_i | input | 1 | Address strobe, active high |
| ds_rd_i | input | 1 | Data strobe (mode 1) or read strobe, active low (mode 0) |
| rw_wr_i | input | 1 | Read/write level (mode 1) or write strobe, active low (mode 0) |
| cs_n_i | input | 1 | Chip select, active low |
| pwr_fail_i | input | 1 | Power-fail inhibit, active high |
| ad_i | input | 8 | Bus value seen at the pins |
| ad_o | output | 8 | Read data to drive onto the bus |
| ad_oe_o | output | 1 | Enable for the bus driver |
| reg_addr_o | output | 7 | Latched register address |
| reg_rd_o | output | 1 | Register read strobe, one cycle |
| reg_wr_o | output | 1 | Register write strobe, one cycle |
| reg_wdata_o | output | 8 | Register write data |
| reg_rdata_i | input | 8 | Register read data for `reg_addr_o` |

## Verification
Some properties are checked by assertions on every cycle: each write and read strobe lasts a single cycle, and a write never follows a sampled power-fail. The bus enable never rises without a qualified chip select. An address strobe edge always loads or clears the address. The bench's cycle-accurate reference model is needed for the rest. It covers the three-cycle latency, the choice of the byte captured at the trailing strobe edge, the read-back of written data in both modes, and the absence of any access when the chip select or the power-fail input blocks the cycle.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
    localparam int BUS_W  = 8;
    localparam int ADDR_W = 7;

    typedef enum logic {
        MODE_SPLIT  = 1'b0,
        MODE_STROBE = 1'b1
    } bus_mode_e;

    // Pin bundle, synchronized as one vector so all bits stay aligned
    typedef struct packed {
        logic             mode;
        logic             as;
        logic             ds;
        logic             rw;
        logic             cs_n;
        logic             pf;
        logic [BUS_W-1:0] ad;
    } bus_pins_t;

    localparam int PINS_W = $bits(bus_pins_t);

    localparam bus_pins_t PINS_IDLE = '{
        mode: 1'b0, as: 1'b0, ds: 1'b0, rw: 1'b1,
        cs_n: 1'b1, pf: 1'b0, ad: '0
    };
endpackage

// File: rtl/mbus_sync_bank.sv
module mbus_sync_bank #(
    parameter int              WIDTH   = 8,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [STAGES-1:0][WIDTH-1:0] stage_d, stage_q;

    always_comb begin
        stage_d[0] = d_i;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= {STAGES{RST_VAL}};
        end else begin
            stage_q <= stage_d;
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/mbus_addr_latch.sv
module mbus_addr_latch #(
    parameter int ADDR_W = 7,
    parameter int BUS_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              as_s_i,
    input  logic [BUS_W-1:0]  ad_s_i,
    output logic [ADDR_W-1:0] addr_o
);
    typedef struct packed {
        logic              as_p;
        logic [ADDR_W-1:0] addr;
    } latch_t;

    latch_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.as_p = as_s_i;
        if (st_q.as_p && !as_s_i) begin
            st_d.addr = ad_s_i[ADDR_W-1:0];
        end else if (!st_q.as_p && as_s_i) begin
            st_d.addr = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign addr_o = st_q.addr;

    assert_addr_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.as_p && !as_s_i) |=> (addr_o == $past(ad_s_i[ADDR_W-1:0])));

    assert_addr_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.as_p && as_s_i) |=> (addr_o == '0));
endmodule

// File: rtl/mbus_cycle_decode.sv
module mbus_cycle_decode
    import mbus_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_mode_e         mode_i,
    input  logic              ds_s_i,
    input  logic              rw_s_i,
    input  logic              sel_ok_i,
    input  logic [DATA_W-1:0] ad_s_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic [DATA_W-1:0] dout_o,
    output logic              oe_o,
    output logic              rd_o,
    output logic              wr_o,
    output logic [DATA_W-1:0] wdata_o
);
    typedef struct packed {
        logic              ds_p;
        logic              rw_p;
        logic              ok_p;
        logic [DATA_W-1:0] ad_p;
        logic              oe;
        logic [DATA_W-1:0] dout;
        logic              wr;
        logic [DATA_W-1:0] wdata;
    } dec_t;

    dec_t st_d, st_q;
    logic read_win;
    logic write_evt;

    always_comb begin
        // Read window: level based, per convention
        if (mode_i == MODE_STROBE) begin
            read_win  = sel_ok_i && ds_s_i && rw_s_i;
            write_evt = st_q.ok_p && st_q.ds_p && !ds_s_i && !st_q.rw_p;
        end else begin
            read_win  = sel_ok_i && !ds_s_i;
            write_evt = st_q.ok_p && !st_q.rw_p && rw_s_i;
        end

        st_d      = st_q;
        st_d.ds_p = ds_s_i;
        st_d.rw_p = rw_s_i;
        st_d.ok_p = sel_ok_i;
        st_d.ad_p = ad_s_i;
        st_d.oe   = read_win;
        st_d.wr   = write_evt;
        if (read_win) begin
            st_d.dout = rdata_i;
        end
        if (write_evt) begin
            st_d.wdata = st_q.ad_p;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign oe_o    = st_q.oe;
    assign dout_o  = st_q.dout;
    assign wr_o    = st_q.wr;
    assign wdata_o = st_q.wdata;
    assign rd_o    = read_win && !st_q.oe;

    assert_wr_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_o |=> !wr_o);

    assert_rd_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_o |=> !rd_o);
endmodule

// File: rtl/mbus_slave.sv
module mbus_slave
    import mbus_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_i,
    input  logic              as_i,
    input  logic              ds_rd_i,
    input  logic              rw_wr_i,
    input  logic              cs_n_i,
    input  logic              pwr_fail_i,
    input  logic [BUS_W-1:0]  ad_i,
    output logic [BUS_W-1:0]  ad_o,
    output logic              ad_oe_o,
    output logic [ADDR_W-1:0] reg_addr_o,
    output logic              reg_rd_o,
    output logic              reg_wr_o,
    output logic [BUS_W-1:0]  reg_wdata_o,
    input  logic [BUS_W-1:0]  reg_rdata_i
);
    bus_pins_t pins_raw, pins_s;
    logic      sel_ok;

    always_comb begin
        pins_raw      = PINS_IDLE;
        pins_raw.mode = mode_i;
        pins_raw.as   = as_i;
        pins_raw.ds   = ds_rd_i;
        pins_raw.rw   = rw_wr_i;
        pins_raw.cs_n = cs_n_i;
        pins_raw.pf   = pwr_fail_i;
        pins_raw.ad   = ad_i;
    end

    mbus_sync_bank #(
        .WIDTH  (PINS_W),
        .STAGES (SYNC_STAGES),
        .RST_VAL(PINS_IDLE)
    ) i_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  (pins_raw),
        .q_o  (pins_s)
    );

    // Power-fail forces the select inactive
    assign sel_ok = !pins_s.cs_n && !pins_s.pf;

    mbus_addr_latch #(
        .ADDR_W(ADDR_W),
        .BUS_W (BUS_W)
    ) i_addr (
        .clk   (clk),
        .rst_n (rst_n),
        .as_s_i(pins_s.as),
        .ad_s_i(pins_s.ad),
        .addr_o(reg_addr_o)
    );

    mbus_cycle_decode #(
        .DATA_W(BUS_W)
    ) i_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_i  (bus_mode_e'(pins_s.mode)),
        .ds_s_i  (pins_s.ds),
        .rw_s_i  (pins_s.rw),
        .sel_ok_i(sel_ok),
        .ad_s_i  (pins_s.ad),
        .rdata_i (reg_rdata_i),
        .dout_o  (ad_o),
        .oe_o    (ad_oe_o),
        .rd_o    (reg_rd_o),
        .wr_o    (reg_wr_o),
        .wdata_o (reg_wdata_o)
    );

    assert_oe_needs_select_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ad_oe_o) |-> $past(sel_ok));

    assert_pf_blocks_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_o |-> !$past(pins_s.pf, 2));
endmodule

// File: tb/test_mbus_slave.sv
module test_mbus_slave;
    import mbus_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic mode = 0, as_p = 0, ds = 1, rw = 1, cs_n = 1, pf = 0;
    logic [7:0] ad = 0;
    logic [7:0] ad_o, wdata, rdata;
    logic [6:0] addr;
    logic oe, rd, wr;

    mbus_slave i_mbus_slave (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .as_i(as_p), .ds_rd_i(ds),
        .rw_wr_i(rw), .cs_n_i(cs_n), .pwr_fail_i(pf), .ad_i(ad), .ad_o(ad_o),
        .ad_oe_o(oe), .reg_addr_o(addr), .reg_rd_o(rd), .reg_wr_o(wr),
        .reg_wdata_o(wdata), .reg_rdata_i(rdata)
    );

    // Register file stand-in
    logic [7:0] mem [128];
    initial for (int i = 0; i < 128; i++) mem[i] = 8'(i * 3 + 1);
    always @(posedge clk) if (wr) mem[addr] <= wdata;
    assign rdata = mem[addr];

    int checks = 0, errors = 0;
    int wr_cnt = 0, rd_cnt = 0;
    logic [7:0] last_rd = 0;
    bit done = 0;

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Reference model: pin history and behavioural state
    bus_pins_t hist[$];
    logic [7:0] m_mem [128];
    initial for (int i = 0; i < 128; i++) m_mem[i] = 8'(i * 3 + 1);
    int m_addr = 0;
    logic [7:0] m_dout = 0;
    bit pend = 0;
    int pend_a = 0;
    logic [7:0] pend_d = 0;

    function automatic bit ra(bus_pins_t h);
        bit ok = !h.cs_n && !h.pf;
        return h.mode ? (ok && h.ds && h.rw) : (ok && !h.ds);
    endfunction

    always @(posedge clk) if (rst_n)
        hist.push_back('{mode:mode, as:as_p, ds:ds, rw:rw, cs_n:cs_n, pf:pf, ad:ad});

    always @(negedge clk) begin
        if (rst_n && hist.size() >= 5) begin
            bus_pins_t h1, h2, h3;
            int prev;
            bit e_oe, e_wr, e_rd;
            logic [7:0] e_wd;
            h1 = hist[hist.size()-2];
            h2 = hist[hist.size()-3];
            h3 = hist[hist.size()-4];
            prev = m_addr;
            if (h3.as && !h2.as) m_addr = int'(h2.ad[6:0]);
            else if (!h3.as && h2.as) m_addr = 0;
            e_oe = ra(h2);
            if (e_oe) m_dout = m_mem[prev];
            if (pend) m_mem[pend_a] = pend_d;
            e_wr = (!h3.cs_n && !h3.pf) &&
                   (h2.mode ? (h3.ds && !h2.ds && !h3.rw) : (!h3.rw && h2.rw));
            e_wd = h3.ad;
            pend = e_wr; pend_a = m_addr; pend_d = e_wd;
            e_rd = ra(h1) && !ra(h2);
            chk(addr == 7'(m_addr), "R2 address", addr, m_addr);
            chk(oe == e_oe, "R4/R6 enable", oe, e_oe);
            chk(wr == e_wr, "R8 write strobe", wr, e_wr);
            if (e_wr) chk(wdata == e_wd, "R5/R7 write data", wdata, e_wd);
            chk(rd == e_rd, "R11 read strobe", rd, e_rd);
            if (e_oe) chk(ad_o == m_dout, "R11 read data", ad_o, m_dout);
            if (wr) wr_cnt++;
            if (rd) rd_cnt++;
            if (oe) last_rd = ad_o;
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic put_addr(logic [7:0] a);
        ad = a; as_p = 1; tick(2);
        as_p = 0; tick(2);
    endtask

    task automatic split_write(logic [7:0] a, logic [7:0] d, bit sel);
        cs_n = !sel; put_addr(a);
        ad = d; rw = 0; tick(3);
        rw = 1; tick(5);
        cs_n = 1; tick(2);
    endtask

    task automatic split_read(logic [7:0] a);
        cs_n = 0; put_addr(a);
        ds = 0; tick(6);
        ds = 1; tick(5);
        cs_n = 1; tick(2);
    endtask

    task automatic strobe_write(logic [7:0] a, logic [7:0] d);
        cs_n = 0; put_addr(a);
        ad = d; rw = 0; ds = 1; tick(3);
        ds = 0; tick(2);
        rw = 1; tick(4);
        cs_n = 1; tick(2);
    endtask

    task automatic strobe_read(logic [7:0] a);
        cs_n = 0; put_addr(a);
        rw = 1; ds = 1; tick(6);
        ds = 0; tick(5);
        cs_n = 1; tick(2);
    endtask

    initial begin
        int w0, r0;
        tick(3);
        chk(oe == 0, "R12 reset enable", oe, 0);
        chk(wr == 0 && rd == 0, "R12 reset strobes", {wr, rd}, 0);
        chk(addr == 0, "R12 reset address", addr, 0);
        rst_n = 1;
        tick(6);

        // Split mode (R1): write then read back, bit 7 of address dropped
        w0 = wr_cnt;
        split_write(8'h95, 8'hA5, 1);
        chk(wr_cnt - w0 == 1, "R8 one pulse per write", wr_cnt - w0, 1);
        chk(addr == 7'h15, "R2 low seven bits", addr, 7'h15);
        r0 = rd_cnt;
        split_read(8'h15);
        chk(rd_cnt - r0 == 1, "R11 one read pulse", rd_cnt - r0, 1);
        chk(last_rd == 8'hA5, "R6 R7 split read-back", last_rd, 8'hA5);

        // Address strobe rise clears with select inactive
        cs_n = 1; ad = 8'h40; as_p = 1; tick(4);
        chk(addr == 0, "R3 clear on strobe rise", addr, 0);
        as_p = 0; tick(4);
        chk(addr == 7'h40, "R9 address latched without select", addr, 7'h40);

        // Deselected write has no effect
        w0 = wr_cnt;
        split_write(8'h15, 8'h3C, 0);
        chk(wr_cnt == w0, "R9 no write without select", wr_cnt - w0, 0);
        split_read(8'h15);
        chk(last_rd == 8'hA5, "R9 data kept", last_rd, 8'hA5);

        // Power fail blocks a selected write
        pf = 1;
        split_write(8'h15, 8'h77, 1);
        chk(wr_cnt == w0, "R10 no write under power fail", wr_cnt - w0, 0);
        pf = 0; tick(3);
        split_read(8'h15);
        chk(last_rd == 8'hA5, "R10 data kept", last_rd, 8'hA5);

        // Data-strobe mode (R1)
        mode = 1; ds = 0; tick(4);
        w0 = wr_cnt;
        strobe_write(8'h22, 8'h5A);
        chk(wr_cnt - w0 == 1, "R5 single write", wr_cnt - w0, 1);
        strobe_read(8'h22);
        chk(last_rd == 8'h5A, "R1 R4 strobe read-back", last_rd, 8'h5A);
        strobe_read(8'h15);
        chk(last_rd == 8'hA5, "R4 other address", last_rd, 8'hA5);
        pf = 1;
        strobe_write(8'h22, 8'h11);
        chk(wr_cnt - w0 == 1, "R10 strobe mode blocked", wr_cnt - w0, 1);
        pf = 0; tick(4);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule